// File: doc/BRIEF.md
# RTC Capture/Compare Channel

This block is one capture/compare channel that sits next to the counters of a real-time clock. It watches two count words supplied from outside: the main count and a combined word that packs pre-counter and counter bits together. A tick strobe marks the cycles on which the counters advance. The channel holds a control register, a compare value and a read-only capture value. In compare mode it drives a match output that can pulse, toggle, clear or set when the chosen count equals the compare value. In capture mode it latches the chosen count when a selected edge appears on an external capture pin.

Each compare match or capture raises a one-cycle event on an interrupt-flag vector, at the bit that belongs to this channel. Two instances, with channel index 0 and 1, form the usual two-channel set. The counters and the bus decoding around the registers are not part of the block.

Top module: `rtc_cc_channel`

## Requirements
- R1: After a synchronous reset, control, compare value, capture value, match output and the interrupt-flag vector all read 0.
- R2: Control bits [1:0] select the mode (0 off, 1 capture, 2 compare; 3 behaves as off). Control bits [3:2] select the match action: 0 makes match_o high for exactly the one cycle after a match and low otherwise, 1 inverts match_o, 2 drives it to 0, 3 drives it to 1.
- R3: Control bit [4] selects the compared and captured word: 0 uses main_cnt_i, 1 uses comb_cnt_i. The unselected word has no effect.
- R4: Control bits [6:5] select the capture edge: 0 rising, 1 falling, 2 both, 3 none. A non-qualifying edge leaves the capture value unchanged.
- R5: The capture pin passes through a two-flop synchroniser. When the pin changes just before clock edge k, the capture value updated at edge k+2 holds the selected word present between edges k+1 and k+2.
- R6: Every compare match or capture produces a single-cycle event on irq_set_o at bit 2 plus the channel index (bit 3 for channel 1); no other bit is ever set.
- R7: A compare match is evaluated only on cycles where tick_i is high; an equal count without tick has no effect.
- R8: With the mode off, match_o keeps its level, no event is raised and the capture value does not change.
- R9: A write to the control or compare register takes effect from the next cycle and reads back on ctrl_o / cmp_val_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter advance strobe |
| main_cnt_i | input | 32 | Main counter value |
| comb_cnt_i | input | 32 | Combined pre-counter/counter word |
| cap_pin_i | input | 1 | Asynchronous capture input |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 7 | Control write data |
| cmp_we_i | input | 1 | Compare value write enable |
| cmp_wdata_i | input | 32 | Compare value write data |
| ctrl_o | output | 7 | Control register contents |
| cmp_val_o | output | 32 | Compare value register |
| cap_val_o | output | 32 | Capture value register (read-only) |
| match_o | output | 1 | Compare match output |
| irq_set_o | output | 4 | One-cycle interrupt flag set vector |

## Verification
Compare mode is driven with a main count sweeping through the compare value under each of the four actions, which separates pulse from level behaviour and toggle from set and clear. A count held equal to the compare value with the tick low, and a combined word that matches while the main count does not, tell tick gating and base selection apart from a plain equality check. Capture mode is driven with rising and falling pin transitions under every edge setting while the count changes each cycle, which shows both the edge qualification and the exact synchroniser latency. A behavioural model compares every output on every clock.

// File: rtl/rtc_cc_pkg.sv
package rtc_cc_pkg;

  localparam int CTRL_W = 7;

  typedef enum logic [1:0] {
    CC_OFF     = 2'd0,
    CC_CAPTURE = 2'd1,
    CC_COMPARE = 2'd2,
    CC_RSVD    = 2'd3
  } cc_mode_e;

  typedef enum logic [1:0] {
    ACT_PULSE  = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } cc_act_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } cc_edge_e;

  typedef struct packed {
    cc_edge_e edge_sel;
    logic     use_comb;
    cc_act_e  action;
    cc_mode_e mode;
  } cc_ctrl_t;

endpackage

// File: rtl/rtc_cc_regs.sv
module rtc_cc_regs
  import rtc_cc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output cc_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0] cmp_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cmp_o  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_o <= cc_ctrl_t'(ctrl_wdata_i);
      if (cmp_we_i)  cmp_o  <= cmp_wdata_i;
    end
  end

  AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cmp_we_i |=> $stable(cmp_o)); // R9

endmodule

// File: rtl/rtc_cc_sync.sv
module rtc_cc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[LAST-1:0], pin_i};
  end

  assign rise_o =  chain_q[LAST-1] & ~chain_q[LAST];
  assign fall_o = ~chain_q[LAST-1] &  chain_q[LAST];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R4

endmodule

// File: rtl/rtc_cc_compare.sv
module rtc_cc_compare
  import rtc_cc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cc_mode_e         mode_i,
  input  cc_act_e          action_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o,
  output logic             match_o
);

  assign hit_o = (mode_i == CC_COMPARE) && tick_i && (cmp_i == cnt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o <= 1'b0;
    end else if (mode_i == CC_COMPARE) begin
      unique case (action_i)
        ACT_PULSE:  match_o <= hit_o;
        ACT_TOGGLE: if (hit_o) match_o <= ~match_o;
        ACT_CLEAR:  if (hit_o) match_o <= 1'b0;
        ACT_SET:    if (hit_o) match_o <= 1'b1;
      endcase
    end
  end

  AST_NO_HIT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_i |-> !hit_o); // R7
  AST_OFF_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (mode_i != CC_COMPARE) |=> $stable(match_o)); // R8
  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (hit_o && action_i == ACT_SET) |=> match_o); // R2
  AST_CLEAR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (hit_o && action_i == ACT_CLEAR) |=> !match_o); // R2

endmodule

// File: rtl/rtc_cc_capture.sv
module rtc_cc_capture
  import rtc_cc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cc_mode_e         mode_i,
  input  cc_edge_e         edge_sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cap_evt_o,
  output logic [CNT_W-1:0] cap_o
);

  logic edge_ok;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: edge_ok = rise_i;
      EDGE_FALL: edge_ok = fall_i;
      EDGE_BOTH: edge_ok = rise_i | fall_i;
      EDGE_NONE: edge_ok = 1'b0;
    endcase
  end

  assign cap_evt_o = (mode_i == CC_CAPTURE) && edge_ok;

  always_ff @(posedge clk) begin
    if (rst)            cap_o <= '0;
    else if (cap_evt_o) cap_o <= cnt_i;
  end

  AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !cap_evt_o |=> $stable(cap_o)); // R4
  AST_CAP_NONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i == EDGE_NONE) |-> !cap_evt_o); // R4

endmodule

// File: rtl/rtc_cc_channel.sv
module rtc_cc_channel
  import rtc_cc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_W      = 4,
  parameter int FLAG_BASE   = 2,
  parameter int CH_IDX      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  main_cnt_i,
  input  logic [CNT_W-1:0]  comb_cnt_i,
  input  logic              cap_pin_i,
  input  logic              ctrl_we_i,
  input  logic [6:0]        ctrl_wdata_i,
  input  logic              cmp_we_i,
  input  logic [CNT_W-1:0]  cmp_wdata_i,
  output logic [6:0]        ctrl_o,
  output logic [CNT_W-1:0]  cmp_val_o,
  output logic [CNT_W-1:0]  cap_val_o,
  output logic              match_o,
  output logic [FLAG_W-1:0] irq_set_o
);

  localparam logic [FLAG_W-1:0] FLAG_MASK = FLAG_W'(1) << (FLAG_BASE + CH_IDX);

  cc_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] sel_cnt;
  logic             rise, fall, hit, cap_evt;
  logic             evt_q;

  rtc_cc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .ctrl_o(ctrl_q), .cmp_o(cmp_val_o)
  );

  rtc_cc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(cap_pin_i),
    .rise_o(rise), .fall_o(fall)
  );

  assign sel_cnt = ctrl_q.use_comb ? comb_cnt_i : main_cnt_i;

  rtc_cc_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst),
    .mode_i(ctrl_q.mode), .action_i(ctrl_q.action),
    .tick_i(tick_i), .cmp_i(cmp_val_o), .cnt_i(sel_cnt),
    .hit_o(hit), .match_o(match_o)
  );

  rtc_cc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst),
    .mode_i(ctrl_q.mode), .edge_sel_i(ctrl_q.edge_sel),
    .rise_i(rise), .fall_i(fall), .cnt_i(sel_cnt),
    .cap_evt_o(cap_evt), .cap_o(cap_val_o)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= hit | cap_evt;
  end

  assign irq_set_o = evt_q ? FLAG_MASK : '0;
  assign ctrl_o    = ctrl_q;

  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_set_o)); // R6
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (hit | cap_evt) |=> (irq_set_o != '0)); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.mode == CC_OFF) |=> (irq_set_o == '0)); // R8

endmodule

// File: tb/rtc_cc_channel_tb.sv
module rtc_cc_channel_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [31:0] main_cnt = '0, comb_cnt = '0;
  logic        cap_pin = 1'b0;
  logic        ctrl_we = 1'b0, cmp_we = 1'b0;
  logic [6:0]  ctrl_wd = '0;
  logic [31:0] cmp_wd = '0;
  logic [6:0]  ctrl_o;
  logic [31:0] cmp_val, cap_val;
  logic        match;
  logic [3:0]  irq_set;

  always #5 clk = ~clk;

  rtc_cc_channel #(.CH_IDX(1)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick),
    .main_cnt_i(main_cnt), .comb_cnt_i(comb_cnt), .cap_pin_i(cap_pin),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .ctrl_o(ctrl_o), .cmp_val_o(cmp_val), .cap_val_o(cap_val),
    .match_o(match), .irq_set_o(irq_set)
  );

  int    errors = 0, checks = 0, cycles = 0, irq_seen = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference model
  int    m_ctrl = 0;
  longint m_cmp = 0, m_cap = 0;
  int    m_match = 0, m_irq = 0;
  int    m_pin[$] = '{0, 0, 0};

  always @(posedge clk) begin
    int mode, act, base, esel, rise, fall, hit, cev;
    longint sel;
    if (rst) begin
      m_ctrl = 0; m_cmp = 0; m_cap = 0; m_match = 0; m_irq = 0;
      m_pin = '{0, 0, 0};
    end else begin
      mode = m_ctrl % 4; act = (m_ctrl / 4) % 4;
      base = (m_ctrl / 16) % 2; esel = (m_ctrl / 32) % 4;
      sel  = base ? longint'(comb_cnt) : longint'(main_cnt);
      rise = (m_pin[1] == 1 && m_pin[2] == 0);
      fall = (m_pin[1] == 0 && m_pin[2] == 1);
      cev  = (mode == 1) && ((esel == 0 && rise) || (esel == 1 && fall) ||
                             (esel == 2 && (rise || fall)));
      hit  = (mode == 2) && tick && (m_cmp == sel);
      if (cev) m_cap = sel;
      if (mode == 2) begin
        if (act == 0) m_match = hit;
        else if (hit) m_match = (act == 1) ? 1 - m_match : (act == 3);
      end
      m_irq = hit || cev;
      if (ctrl_we) m_ctrl = int'(ctrl_wd);
      if (cmp_we)  m_cmp  = longint'(cmp_wd);
      void'(m_pin.pop_back());
      m_pin.push_front(int'(cap_pin));
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (irq_set != 0) irq_seen++;
    if (!done) begin
      check({cur_req, " match"}, match, m_match);
      check({cur_req, " irq"}, irq_set, m_irq ? 8 : 0);
      check({cur_req, " cap"}, cap_val, m_cap);
      check({cur_req, " cmp"}, cmp_val, m_cmp);
      check({cur_req, " ctrl"}, ctrl_o, m_ctrl);
    end
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [6:0] v);
    ctrl_wd = v; ctrl_we = 1; step(1); ctrl_we = 0;
  endtask

  task automatic wr_cmp(logic [31:0] v);
    cmp_wd = v; cmp_we = 1; step(1); cmp_we = 0;
  endtask

  task automatic tick_once;
    tick = 1; step(1); tick = 0; step(2);
  endtask

  initial begin
    step(3); rst = 0; step(1);
    cur_req = "R1";
    check("R1 reset match", match, 0);
    check("R1 reset cap", cap_val, 0);
    check("R1 reset irq", irq_set, 0);

    // R2 set action with main count sweep, R9 register writes
    cur_req = "R2"; wr_cmp(32'd100); wr_ctrl(7'h0E);
    check("R9 cmp readback", cmp_val, 100);
    check("R9 ctrl readback", ctrl_o, 7'h0E);
    irq_seen = 0; tick = 1;
    for (int v = 95; v < 105; v++) begin main_cnt = v; step(1); end
    tick = 0; step(2);
    check("R2 set level", match, 1);
    check("R6 one event per match", irq_seen, 1);

    // R7 tick gating with toggle
    cur_req = "R7"; wr_ctrl(7'h06); main_cnt = 100; step(5);
    check("R7 no tick no toggle", match, 1);
    cur_req = "R2"; tick_once;
    check("R2 toggle", match, 0);
    tick_once;
    check("R2 toggle back", match, 1);
    wr_ctrl(7'h0A); tick_once;
    check("R2 clear", match, 0);

    // pulse
    wr_ctrl(7'h02); irq_seen = 0;
    tick = 1; step(1); tick = 0;
    check("R2 pulse high", match, 1);
    step(1);
    check("R2 pulse one cycle", match, 0);

    // R3 combined base
    cur_req = "R3"; wr_ctrl(7'h1E); wr_cmp(32'h8005);
    main_cnt = 32'h8005; comb_cnt = 32'h1; tick_once;
    check("R3 main ignored", match, 0);
    comb_cnt = 32'h8005; tick_once;
    check("R3 comb match", match, 1);

    // R8 mode off
    cur_req = "R8"; wr_ctrl(7'h40); irq_seen = 0;
    for (int i = 0; i < 4; i++) begin cap_pin = ~cap_pin; tick = 1; step(4); end
    tick = 0; step(4);
    check("R8 level held", match, 1);
    check("R8 no events", irq_seen, 0);
    check("R8 no capture", cap_val, 0);

    // R4 edge selection
    cur_req = "R4"; wr_ctrl(7'h01); irq_seen = 0;
    main_cnt = 32'h1234; cap_pin = 1; step(6);
    check("R4 rising captured", cap_val, 32'h1234);
    check("R6 capture event", irq_seen, 1);
    main_cnt = 32'h2222; cap_pin = 0; step(6);
    check("R4 falling ignored on rise", cap_val, 32'h1234);
    wr_ctrl(7'h21); main_cnt = 32'h3333; cap_pin = 1; step(6);
    check("R4 rising ignored on fall", cap_val, 32'h1234);
    cap_pin = 0; step(6);
    check("R4 falling captured", cap_val, 32'h3333);
    wr_ctrl(7'h41); main_cnt = 32'h4444; cap_pin = 1; step(6);
    check("R4 both rise", cap_val, 32'h4444);
    main_cnt = 32'h5555; cap_pin = 0; step(6);
    check("R4 both fall", cap_val, 32'h5555);
    wr_ctrl(7'h61); main_cnt = 32'h6666; irq_seen = 0;
    cap_pin = 1; step(6); cap_pin = 0; step(6);
    check("R4 none ignored", cap_val, 32'h5555);
    check("R4 none no event", irq_seen, 0);

    // R3 capture of combined word
    cur_req = "R3"; wr_ctrl(7'h11); comb_cnt = 32'h7777; main_cnt = 32'h1;
    cap_pin = 1; step(6);
    check("R3 comb captured", cap_val, 32'h7777);
    cap_pin = 0; step(4);

    // R5 synchroniser latency
    cur_req = "R5"; wr_ctrl(7'h01); main_cnt = 32'h0F0; step(2);
    cap_pin = 1; step(1); main_cnt = 32'h100; step(1);
    main_cnt = 32'h200; step(1); main_cnt = 32'h300; step(1);
    main_cnt = 32'h400; step(3);
    check("R5 latency", cap_val, 32'h200);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule